// File: doc/BRIEF.md
# SD Card Single-Block Data Mover (SPI Mode)

This block carries out the data phase of one block transfer with an SD card that is run in SPI mode. Another unit has already sent the read or write command (its address argument is the block number times 512) and seen it accepted. It then pulses `start` with a direction and a length: a full 512-byte data block, or a 16-byte register image. The mover exchanges bytes with an SPI shifter one at a time and drives the card's chip select. It also moves the payload between the card and a byte-wide buffer, whose addresses count up from 0 in transfer order.

On a read it keeps sending 0xFF until the card returns the 0xFE start token. It then stores the payload and clocks in two CRC bytes, which it discards. On a write it sends 0xFE, then the payload, then two 0xFF bytes in place of a CRC. It decodes the card's acknowledge byte and, when the write is accepted, polls until the card stops signalling busy. The token hunt and the busy poll are each bounded by a byte limit supplied at start. Every transfer ends by releasing chip select and sending one more 0xFF byte. A one-cycle `done` then presents the result code.

Top module: `sd_block_xfer`

## Requirements
- R1: After reset, `csN` is 1, `busy` and `done` are 0, and no byte exchange is requested.
- R2: On a read (`dirWrite`=0), the block sends 0xFF and keeps exchanging until a received byte equals 0xFE. No byte received before the 0xFE is written to the buffer.
- R3: After the 0xFE token, N bytes are written to buffer addresses 0..N-1 in receive order. N is 16 when `regRead`=1 and 512 otherwise. Two more bytes are then exchanged and not stored. Every byte sent during a read is 0xFF.
- R4: On a write (`dirWrite`=1), the sent bytes are 0xFE, then buffer bytes 0..N-1 in address order, then 0xFF, 0xFF. No buffer write occurs during a write transfer.
- R5: On a write, the byte received after the two CRC fillers is the acknowledge. If (ack & 0x1F) = 0x05 the write is accepted. Otherwise the status field ack[3:1] selects the error: 3'b101 gives `errCode` 2, 3'b110 gives 3, and any other value gives 4. After a rejection no busy polling takes place.
- R6: After an accepted write, 0xFF is sent while the received byte is 0x00. The first nonzero byte ends the busy phase.
- R7: With L = max(`timeoutLimit`,1), the token hunt and the busy poll each exchange at most L bytes. If the hunt ends with no 0xFE the code is 1. If the busy poll sees L zero bytes the code is 5. A 0xFE or a nonzero byte arriving on the L-th exchange is still a success.
- R8: `csN` is 0 for every exchange of the transfer except the last one. The last exchange is a 0xFF sent with `csN`=1. When it completes, `done` pulses for one cycle with `errCode` (0 = success). `busy` is 0 in the next cycle.
- R9: At most one byte exchange is outstanding: no new `spiTxValid` is raised until `spiRxValid` has returned the previous byte.
- R10: `start` is ignored while `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer (taken only when idle) |
| dirWrite | input | 1 | 1 = write to card, 0 = read from card |
| regRead | input | 1 | 1 = 16-byte payload, 0 = 512-byte payload |
| timeoutLimit | input | TMO_W | Byte limit for token hunt and busy poll |
| spiTxValid | output | 1 | Request one byte exchange |
| spiTxData | output | 8 | Byte to shift out |
| spiRxValid | input | 1 | Exchange finished, received byte valid |
| spiRxData | input | 8 | Byte shifted in |
| csN | output | 1 | Card chip select, active low |
| bufAddr | output | ADDR_W | Buffer byte address |
| bufWrData | output | 8 | Byte to store in buffer |
| bufWrEn | output | 1 | Buffer write strobe |
| bufRdData | input | 8 | Buffer byte at `bufAddr` (combinational read) |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| errCode | output | 3 | Result code, valid with `done` |

## Verification
The bench builds the block with its default parameters: 512-byte blocks, a 16-byte register payload and a 16-bit limit counter. Both payload lengths and the full address range of the buffer are therefore covered. The limit is set to small values at run time. This brings the hunt and busy timeouts, and the success exactly on the L-th byte, within a few exchanges of the data phase. The card-side model replays scripted byte streams, so each acknowledge status and each busy length can be placed at will.

// File: rtl/sd_xfer_pkg.sv
package sd_xfer_pkg;

  typedef enum logic [1:0] {
    TX_FILL  = 2'd0,
    TX_START = 2'd1,
    TX_BUF   = 2'd2
  } txSel_e;

  // Strobes from control to datapath, one set per cycle
  typedef struct packed {
    logic   loadCfg;
    logic   clrCnt;
    logic   incCnt;
    logic   clrAddr;
    logic   incAddr;
    logic   storeByte;
    txSel_e txSel;
  } dpStrobe_t;

  localparam logic [7:0] FILL_BYTE   = 8'hFF;
  localparam logic [7:0] START_TOKEN = 8'hFE;

  localparam logic [2:0] ERR_NONE      = 3'd0;
  localparam logic [2:0] ERR_HUNT_TMO  = 3'd1;
  localparam logic [2:0] ERR_CRC_REJ   = 3'd2;
  localparam logic [2:0] ERR_WR_REJ    = 3'd3;
  localparam logic [2:0] ERR_BAD_TOKEN = 3'd4;
  localparam logic [2:0] ERR_BUSY_TMO  = 3'd5;

endpackage

// File: rtl/sd_xfer_dp.sv
module sd_xfer_dp
  import sd_xfer_pkg::*;
#(
  parameter int BLOCK_BYTES = 512,
  parameter int REG_BYTES   = 16,
  parameter int TMO_W       = 16,
  localparam int ADDR_W     = $clog2(BLOCK_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         str,
  input  logic              regRead,
  input  logic [TMO_W-1:0]  timeoutLimit,
  input  logic [7:0]        spiRxData,
  input  logic [7:0]        bufRdData,
  output logic [7:0]        spiTxData,
  output logic [ADDR_W-1:0] bufAddr,
  output logic [7:0]        bufWrData,
  output logic              bufWrEn,
  output logic              lastByte,
  output logic              cntHit,
  output logic              cntOdd
);

  localparam logic [ADDR_W-1:0] BLK_LAST = ADDR_W'(BLOCK_BYTES - 1);
  localparam logic [ADDR_W-1:0] REG_LAST = ADDR_W'(REG_BYTES - 1);

  logic [ADDR_W-1:0] addrQ;
  logic [TMO_W-1:0]  cntQ;
  logic [TMO_W-1:0]  limitQ;
  logic              regSelQ;
  logic [TMO_W:0]    cntPlus;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regSelQ <= 1'b0;
      limitQ  <= '0;
    end else if (str.loadCfg) begin
      regSelQ <= regRead;
      limitQ  <= timeoutLimit;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            addrQ <= '0;
    else if (str.clrAddr) addrQ <= '0;
    else if (str.incAddr) addrQ <= addrQ + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           cntQ <= '0;
    else if (str.clrCnt) cntQ <= '0;
    else if (str.incCnt) cntQ <= cntQ + 1'b1;
  end

  // Byte about to be counted reaches the limit (a limit of 0 acts as 1)
  assign cntPlus  = {1'b0, cntQ} + {{TMO_W{1'b0}}, 1'b1};
  assign cntHit   = cntPlus >= {1'b0, limitQ};
  assign cntOdd   = cntQ[0];
  assign lastByte = addrQ == (regSelQ ? REG_LAST : BLK_LAST);

  always_comb begin
    case (str.txSel)
      TX_START: spiTxData = START_TOKEN;
      TX_BUF:   spiTxData = bufRdData;
      default:  spiTxData = FILL_BYTE;
    endcase
  end

  assign bufAddr   = addrQ;
  assign bufWrData = spiRxData;
  assign bufWrEn   = str.storeByte;

endmodule

// File: rtl/sd_xfer_ctrl.sv
module sd_xfer_ctrl
  import sd_xfer_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       dirWrite,
  input  logic       spiRxValid,
  input  logic [7:0] spiRxData,
  input  logic       lastByte,
  input  logic       cntHit,
  input  logic       cntOdd,
  output dpStrobe_t  str,
  output logic       spiTxValid,
  output logic       csN,
  output logic       busy,
  output logic       done,
  output logic [2:0] errCode
);

  typedef enum logic [2:0] {
    S_IDLE, S_HUNT, S_TOKEN, S_DATA, S_CRC, S_RESP, S_BUSY, S_TAIL
  } state_e;

  state_e     stateQ, stateD;
  logic       waitingQ;
  logic       isWriteQ;
  logic [2:0] errQ, errD;
  logic       rxDone;

  assign rxDone = waitingQ && spiRxValid;

  always_comb begin
    str       = '0;
    str.txSel = TX_FILL;
    stateD    = stateQ;
    errD      = errQ;
    done      = 1'b0;
    case (stateQ)
      S_IDLE: if (start) begin
        str.loadCfg = 1'b1;
        str.clrCnt  = 1'b1;
        str.clrAddr = 1'b1;
        errD        = ERR_NONE;
        stateD      = dirWrite ? S_TOKEN : S_HUNT;
      end
      S_HUNT: if (rxDone) begin
        if (spiRxData == START_TOKEN) begin
          str.clrCnt = 1'b1;
          stateD     = S_DATA;
        end else if (cntHit) begin
          errD   = ERR_HUNT_TMO;
          stateD = S_TAIL;
        end else begin
          str.incCnt = 1'b1;
        end
      end
      S_TOKEN: begin
        str.txSel = TX_START;
        if (rxDone) stateD = S_DATA;
      end
      S_DATA: begin
        str.txSel = isWriteQ ? TX_BUF : TX_FILL;
        if (rxDone) begin
          str.storeByte = !isWriteQ;
          str.incAddr   = 1'b1;
          if (lastByte) begin
            str.clrCnt = 1'b1;
            stateD     = S_CRC;
          end
        end
      end
      S_CRC: if (rxDone) begin
        if (cntOdd) begin
          str.clrCnt = 1'b1;
          stateD     = isWriteQ ? S_RESP : S_TAIL;
        end else begin
          str.incCnt = 1'b1;
        end
      end
      S_RESP: if (rxDone) begin
        if (spiRxData[4:0] == 5'h05) begin
          stateD = S_BUSY;
        end else begin
          case (spiRxData[3:1])
            3'b101:  errD = ERR_CRC_REJ;
            3'b110:  errD = ERR_WR_REJ;
            default: errD = ERR_BAD_TOKEN;
          endcase
          stateD = S_TAIL;
        end
      end
      S_BUSY: if (rxDone) begin
        if (spiRxData != 8'h00) begin
          stateD = S_TAIL;
        end else if (cntHit) begin
          errD   = ERR_BUSY_TMO;
          stateD = S_TAIL;
        end else begin
          str.incCnt = 1'b1;
        end
      end
      S_TAIL: if (rxDone) begin
        done   = 1'b1;
        stateD = S_IDLE;
      end
      default: stateD = S_IDLE;
    endcase
  end

  assign spiTxValid = (stateQ != S_IDLE) && !waitingQ;
  assign csN        = (stateQ == S_IDLE) || (stateQ == S_TAIL);
  assign busy       = stateQ != S_IDLE;
  assign errCode    = errQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= S_IDLE;
      waitingQ <= 1'b0;
      isWriteQ <= 1'b0;
      errQ     <= ERR_NONE;
    end else begin
      stateQ <= stateD;
      errQ   <= errD;
      if (spiTxValid)      waitingQ <= 1'b1;
      else if (spiRxValid) waitingQ <= 1'b0;
      if (stateQ == S_IDLE && start) isWriteQ <= dirWrite;
    end
  end

endmodule

// File: rtl/sd_block_xfer.sv
module sd_block_xfer
  import sd_xfer_pkg::*;
#(
  parameter int BLOCK_BYTES = 512,
  parameter int REG_BYTES   = 16,
  parameter int TMO_W       = 16,
  localparam int ADDR_W     = $clog2(BLOCK_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              dirWrite,
  input  logic              regRead,
  input  logic [TMO_W-1:0]  timeoutLimit,
  output logic              spiTxValid,
  output logic [7:0]        spiTxData,
  input  logic              spiRxValid,
  input  logic [7:0]        spiRxData,
  output logic              csN,
  output logic [ADDR_W-1:0] bufAddr,
  output logic [7:0]        bufWrData,
  output logic              bufWrEn,
  input  logic [7:0]        bufRdData,
  output logic              busy,
  output logic              done,
  output logic [2:0]        errCode
);

  dpStrobe_t str;
  logic      lastByte, cntHit, cntOdd;

  sd_xfer_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .dirWrite(dirWrite),
    .spiRxValid(spiRxValid), .spiRxData(spiRxData),
    .lastByte(lastByte), .cntHit(cntHit), .cntOdd(cntOdd),
    .str(str), .spiTxValid(spiTxValid), .csN(csN), .busy(busy),
    .done(done), .errCode(errCode)
  );

  sd_xfer_dp #(
    .BLOCK_BYTES(BLOCK_BYTES), .REG_BYTES(REG_BYTES), .TMO_W(TMO_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .str(str), .regRead(regRead),
    .timeoutLimit(timeoutLimit), .spiRxData(spiRxData), .bufRdData(bufRdData),
    .spiTxData(spiTxData), .bufAddr(bufAddr), .bufWrData(bufWrData),
    .bufWrEn(bufWrEn), .lastByte(lastByte), .cntHit(cntHit), .cntOdd(cntOdd)
  );

endmodule

// File: rtl/sd_block_xfer_chk.sv
module sd_block_xfer_chk (
  input logic       clk,
  input logic       rstN,
  input logic       busy,
  input logic       csN,
  input logic       done,
  input logic       spiTxValid,
  input logic [7:0] spiTxData,
  input logic       spiRxValid,
  input logic       bufWrEn
);

  logic pendQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           pendQ <= 1'b0;
    else if (spiTxValid) pendQ <= 1'b1;
    else if (spiRxValid) pendQ <= 1'b0;
  end

  p_cs_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> csN);

  p_single_req_r9: assert property (@(posedge clk) disable iff (!rstN)
    spiTxValid |-> !pendQ);

  p_tail_fill_r8: assert property (@(posedge clk) disable iff (!rstN)
    (spiTxValid && csN) |-> spiTxData == 8'hFF);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !busy));

  p_done_cs_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> csN);

  p_store_selected_r3: assert property (@(posedge clk) disable iff (!rstN)
    bufWrEn |-> (busy && !csN));

endmodule

bind sd_block_xfer sd_block_xfer_chk u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .csN(csN), .done(done),
  .spiTxValid(spiTxValid), .spiTxData(spiTxData),
  .spiRxValid(spiRxValid), .bufWrEn(bufWrEn)
);

// File: tb/sd_block_xfer_tb.sv
module sd_block_xfer_tb;

  localparam int CLK_PERIOD = 10;
  localparam int BLK = 512;
  localparam int RGB = 16;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0, dirWrite = 1'b0, regRead = 1'b0;
  logic [15:0] timeoutLimit = 16'd8;
  logic       spiTxValid, spiRxValid = 1'b0;
  logic [7:0] spiTxData, spiRxData = 8'hFF;
  logic       csN, bufWrEn, busy, done;
  logic [8:0] bufAddr;
  logic [7:0] bufWrData, bufRdData;
  logic [2:0] errCode;

  logic [7:0] srcMem [0:BLK-1];
  logic [7:0] dstMem [0:BLK-1];
  logic [7:0] rxScript [0:2047];
  logic [7:0] txLog [0:2047];
  logic       csLog [0:2047];
  logic [7:0] rxFill = 8'hFF;
  int scriptLen = 0, exIdx = 0, doneCnt = 0, wrCount = 0;
  logic [2:0] lastErr = 3'd0;
  int checks = 0, failures = 0;
  bit watchdogHit = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sd_block_xfer u_dut (
    .clk(clk), .rstN(rstN), .start(start), .dirWrite(dirWrite),
    .regRead(regRead), .timeoutLimit(timeoutLimit),
    .spiTxValid(spiTxValid), .spiTxData(spiTxData),
    .spiRxValid(spiRxValid), .spiRxData(spiRxData), .csN(csN),
    .bufAddr(bufAddr), .bufWrData(bufWrData), .bufWrEn(bufWrEn),
    .bufRdData(bufRdData), .busy(busy), .done(done), .errCode(errCode)
  );

  assign bufRdData = srcMem[bufAddr];

  always @(posedge clk) begin
    if (bufWrEn) begin
      dstMem[bufAddr] <= bufWrData;
      wrCount <= wrCount + 1;
    end
  end

  // Card / SPI shifter model: one exchange takes two cycles
  initial begin
    forever begin
      @(negedge clk);
      spiRxValid = 1'b0;
      if (spiTxValid) begin
        if (exIdx < 2048) begin
          txLog[exIdx] = spiTxData;
          csLog[exIdx] = csN;
        end
        @(negedge clk);
        spiRxData  = (exIdx < scriptLen) ? rxScript[exIdx] : rxFill;
        spiRxValid = 1'b1;
        exIdx++;
        #1;
        if (done) begin
          doneCnt++;
          lastErr = errCode;
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Read script: k filler bytes, token, payload, two CRC bytes
  task automatic buildRead(input int k, input int n, output logic [7:0] data [0:BLK-1]);
    for (int i = 0; i < k; i++) rxScript[i] = (i % 3 == 0) ? 8'hFF : 8'h7F;
    rxScript[k] = 8'hFE;
    for (int i = 0; i < n; i++) begin
      data[i] = 8'($urandom);
      rxScript[k+1+i] = data[i];
    end
    rxScript[k+1+n] = 8'hA5;
    rxScript[k+2+n] = 8'h5A;
    scriptLen = k + 3 + n;
    rxFill = 8'hFF;
  endtask

  // Write script: FF during token/data/CRC, ack, b busy zeros, then release
  task automatic buildWrite(input int n, input logic [7:0] ack, input int b, input logic [7:0] fill);
    for (int i = 0; i < n + 3; i++) rxScript[i] = 8'hFF;
    rxScript[n+3] = ack;
    for (int i = 0; i < b; i++) rxScript[n+4+i] = 8'h00;
    rxScript[n+4+b] = 8'h01;
    scriptLen = n + 5 + b;
    rxFill = fill;
  endtask

  task automatic runXfer(input logic wr, input logic rg, input int lim, input bit poke);
    int d0;
    int guard;
    d0 = doneCnt;
    exIdx = 0;
    @(negedge clk);
    dirWrite = wr; regRead = rg; timeoutLimit = 16'(lim); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (40) @(negedge clk);
      start = 1'b1; dirWrite = ~wr; regRead = ~rg;
      @(negedge clk);
      start = 1'b0;
    end
    guard = 0;
    while (doneCnt == d0 && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    if (guard >= 20000) begin
      watchdogHit = 1'b1;
      check(1'b0, "R8 transfer never completed", guard, 0);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic checkFrame(input string tag, input logic wr, input int n, input int total);
    int bad;
    int firstBad;
    logic [7:0] expTx;
    bad = 0; firstBad = -1;
    for (int j = 0; j < total && j < 2048; j++) begin
      if (wr && j == 0) expTx = 8'hFE;
      else if (wr && j >= 1 && j <= n) expTx = srcMem[j-1];
      else expTx = 8'hFF;
      if (txLog[j] !== expTx || csLog[j] !== (j == total - 1)) begin
        bad++;
        if (firstBad < 0) firstBad = j;
      end
    end
    check(exIdx == total, {tag, " exchange count"}, exIdx, total);
    check(bad == 0, {tag, " tx bytes / cs per exchange (first bad index)"}, firstBad, -1);
  endtask

  initial begin
    logic [7:0] rdData [0:BLK-1];
    int k, b, w0, total, bad;
    logic [7:0] keep16;
    void'($urandom(32'h5D0C_1A7E));
    for (int i = 0; i < BLK; i++) begin
      srcMem[i] = 8'($urandom);
      dstMem[i] = 8'h00;
    end

    fork
      begin
        repeat (190000) @(negedge clk);
        watchdogHit = 1'b1;
      end
    join_none

    repeat (3) @(negedge clk);
    // R1: reset state
    check(csN === 1'b1, "R1 csN in reset", csN, 1);
    check(busy === 1'b0 && done === 1'b0, "R1 busy/done in reset", {busy, done}, 0);
    check(spiTxValid === 1'b0, "R1 no request in reset", spiTxValid, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(spiTxValid === 1'b0 && csN === 1'b1, "R1 idle after reset", spiTxValid, 0);

    // R2 R3 R8: full block read after random filler
    k = $urandom_range(0, 6);
    buildRead(k, BLK, rdData);
    w0 = wrCount;
    runXfer(1'b0, 1'b0, 16, 1'b0);
    check(lastErr == 3'd0, "R3 read result", lastErr, 0);
    checkFrame("R2 R8 read", 1'b0, BLK, k + 1 + BLK + 3);
    check(wrCount - w0 == BLK, "R3 stored byte count", wrCount - w0, BLK);
    bad = 0;
    for (int i = 0; i < BLK; i++) if (dstMem[i] !== rdData[i]) bad++;
    check(bad == 0, "R3 buffer contents in order", bad, 0);
    keep16 = dstMem[RGB];

    // R3: register read of 16 bytes
    buildRead(0, RGB, rdData);
    w0 = wrCount;
    runXfer(1'b0, 1'b1, 16, 1'b0);
    checkFrame("R3 reg read", 1'b0, RGB, 1 + RGB + 3);
    check(wrCount - w0 == RGB, "R3 reg read stored count", wrCount - w0, RGB);
    bad = 0;
    for (int i = 0; i < RGB; i++) if (dstMem[i] !== rdData[i]) bad++;
    check(bad == 0 && dstMem[RGB] == keep16, "R3 reg read contents, byte 16 untouched", bad, 0);

    // R7: token on the L-th hunt byte still succeeds
    buildRead(4, RGB, rdData);
    runXfer(1'b0, 1'b1, 5, 1'b0);
    check(lastErr == 3'd0, "R7 token on last allowed byte", lastErr, 0);
    check(exIdx == 5 + RGB + 3, "R7 boundary exchange count", exIdx, 5 + RGB + 3);

    // R7 R2: hunt timeout, nothing stored
    scriptLen = 0; rxFill = 8'hFF;
    w0 = wrCount;
    runXfer(1'b0, 1'b0, 5, 1'b0);
    check(lastErr == 3'd1, "R7 hunt timeout code", lastErr, 1);
    checkFrame("R7 hunt timeout", 1'b0, 0, 6);
    check(wrCount == w0, "R2 no store on timeout", wrCount - w0, 0);

    // R4 R5 R6: accepted write with busy phase
    b = $urandom_range(0, 5);
    buildWrite(BLK, 8'hE5, b, 8'hFF);
    w0 = wrCount;
    runXfer(1'b1, 1'b0, 8, 1'b0);
    check(lastErr == 3'd0, "R5 accepted write", lastErr, 0);
    checkFrame("R4 R6 write", 1'b1, BLK, BLK + 4 + b + 1 + 1);
    check(wrCount == w0, "R4 no buffer write during write", wrCount - w0, 0);

    // R5: rejections, no busy phase
    buildWrite(BLK, 8'h0B, 0, 8'h00);
    runXfer(1'b1, 1'b0, 8, 1'b0);
    check(lastErr == 3'd2, "R5 status 101", lastErr, 2);
    check(exIdx == BLK + 5, "R5 no busy after crc reject", exIdx, BLK + 5);
    buildWrite(RGB, 8'hFD, 0, 8'h00);
    runXfer(1'b1, 1'b1, 8, 1'b0);
    check(lastErr == 3'd3, "R5 status 110", lastErr, 3);
    checkFrame("R5 write reject", 1'b1, RGB, RGB + 5);
    buildWrite(RGB, 8'h0F, 0, 8'h00);
    runXfer(1'b1, 1'b1, 8, 1'b0);
    check(lastErr == 3'd4, "R5 other status", lastErr, 4);

    // R7 R6: busy timeout and busy boundary
    buildWrite(RGB, 8'h05, 0, 8'h00);
    scriptLen = RGB + 4;
    runXfer(1'b1, 1'b1, 3, 1'b0);
    check(lastErr == 3'd5, "R7 busy timeout code", lastErr, 5);
    check(exIdx == RGB + 4 + 3 + 1, "R7 busy timeout count", exIdx, RGB + 8);
    buildWrite(RGB, 8'h05, 2, 8'h00);
    runXfer(1'b1, 1'b1, 3, 1'b0);
    check(lastErr == 3'd0, "R6 release on L-th busy byte", lastErr, 0);
    check(exIdx == RGB + 4 + 3 + 1, "R6 busy boundary count", exIdx, RGB + 8);

    // R10: start pulsed mid-transfer is ignored
    buildRead(1, RGB, rdData);
    runXfer(1'b0, 1'b1, 8, 1'b1);
    check(lastErr == 3'd0, "R10 result with stray start", lastErr, 0);
    checkFrame("R10 stray start", 1'b0, RGB, 2 + RGB + 3);

    // Constrained random mix
    for (int it = 0; it < 6; it++) begin
      logic wr, rg;
      int n, lim;
      wr = 1'($urandom); rg = 1'($urandom);
      n = rg ? RGB : BLK;
      lim = $urandom_range(2, 6);
      if (wr) begin
        b = $urandom_range(0, lim - 1);
        buildWrite(n, 8'h05 | (8'($urandom_range(0, 7)) << 5), b, 8'h00);
        runXfer(wr, rg, lim, 1'b0);
        check(lastErr == 3'd0, "R6 random write", lastErr, 0);
        checkFrame("R4 random write", 1'b1, n, n + 4 + b + 2);
      end else begin
        k = $urandom_range(0, lim - 1);
        buildRead(k, n, rdData);
        runXfer(wr, rg, lim, 1'b0);
        bad = 0;
        for (int i = 0; i < n; i++) if (dstMem[i] !== rdData[i]) bad++;
        check(lastErr == 3'd0 && bad == 0, "R3 random read", bad, 0);
        checkFrame("R2 random read", 1'b0, n, k + n + 4);
      end
    end

    if (watchdogHit) check(1'b0, "watchdog expired", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait (watchdogHit);
    check(1'b0, "watchdog expired", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule